// File: doc/BRIEF.md
# Mains Half-Period Calibrator

This block runs once after reset. It measures how long one half-cycle of the mains supply lasts and turns that length into the divider setting for the prescaler that clocks the lamp firing counters. With that divider, 256 firing-counter ticks fill exactly one half-cycle, whether the line runs at 47 Hz, at 63 Hz or anywhere between.

The input is a stream of single-cycle zero-crossing pulses, already synchronised to `clk`. The first pulse after reset starts a measurement counter. This counter advances once every `CAL_DIV*SLOW_DIV` clock cycles: the calibration divider multiplied by the slow-down factor. It runs across `HALF_CYCLES` further half-cycles. Averaging over many half-cycles with a slowed counter gives about the same count as a single half-cycle measured at the faster rate, but it is far less sensitive to jitter. The block then multiplies the count by `CAL_DIV` and shifts the result right by 8. The result is clamped to the range 1 to the largest value the divider can hold. It is held on `div_val` and `cal_done` goes high.

From then on, zero crossings pass straight through to `zc_fwd`, which feeds the firing controller. If the line goes quiet before calibration completes, the block raises `cal_err` and never completes.

Top module: `mains_cal`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cal_done`, `cal_err`, `zc_fwd` and `div_val` are all 0.
- R2: The first `zc_in` pulse after reset starts the measurement. The raw count equals the number of whole periods of `CAL_DIV*SLOW_DIV` clock cycles in the span E. E is the number of clock edges from the starting pulse to the `HALF_CYCLES`-th pulse after it, and the count saturates at 2^`CNT_W`-1.
- R3: `cal_done` rises in the cycle after the clock edge that samples the `HALF_CYCLES`-th pulse after the starting one. It stays high until reset.
- R4: When `cal_done` rises, `div_val` equals (count × `CAL_DIV`) >> 8.
- R5: A result above 2^`DIV_W`-1 is presented as 2^`DIV_W`-1.
- R6: A result of 0 is presented as 1. While `cal_done` is high, `div_val` is never 0.
- R7: `zc_fwd` is `zc_in` ANDed with `cal_done`. The pulse that completes calibration is not forwarded.
- R8: Before `cal_done` is set, if `TIMEOUT` consecutive clock edges pass without a pulse, `cal_err` rises after the `TIMEOUT`-th edge. It stays high until reset, and `cal_done` stays low.
- R9: Zero crossings after `cal_done` is set leave `div_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zc_in | input | 1 | Single-cycle zero-crossing pulse |
| zc_fwd | output | 1 | Zero crossing forwarded to the firing controller once calibrated |
| div_val | output | DIV_W | Computed prescaler divider |
| cal_done | output | 1 | Calibration complete |
| cal_err | output | 1 | No crossing seen within `TIMEOUT` cycles before completion |

## Verification
The assertions check, on every cycle, the properties that hold cycle by cycle:
- `cal_done` and `cal_err` are never high together, and each one stays high once set.
- `div_val` is non-zero and stays unchanged while calibrated.
- `zc_fwd` never fires unless both `cal_done` and `zc_in` are high.

The actual divider value depends on the count accumulated over thousands of cycles and on clamping at both ends, so only the bench scenarios can show it is right. These scenarios use several line periods, uneven pulse spacing, an overflow and an underflow, and they also show when the timeout fires, both before the first pulse and in the middle of a measurement.

// File: rtl/mains_cal.sv
module mains_cal #(
  parameter int HALF_CYCLES = 16,
  parameter int SLOW_DIV    = 16,
  parameter int CAL_DIV     = 100,
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 16,
  parameter int TIMEOUT     = 5_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_in,
  output logic             zc_fwd,
  output logic [DIV_W-1:0] div_val,
  output logic             cal_done,
  output logic             cal_err
);
  localparam int TICK   = CAL_DIV * SLOW_DIV;
  localparam int PS_W   = (TICK > 1) ? $clog2(TICK) : 1;
  localparam int HC_W   = $clog2(HALF_CYCLES + 1);
  localparam int TO_W   = $clog2(TIMEOUT + 1);
  localparam int CAL_W  = $clog2(CAL_DIV + 1);
  localparam int PROD_W = CNT_W + CAL_W + DIV_W;
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PROD_W-1:0] DIV_CAP = {{(PROD_W-DIV_W){1'b0}}, {DIV_W{1'b1}}};

  typedef enum logic [1:0] {WAIT_FIRST, MEASURE, CALIBRATED, FAILED} phase_t;

  phase_t            phase;
  logic [PS_W-1:0]   pre;
  logic [CNT_W-1:0]  cnt;
  logic [HC_W-1:0]   halves;
  logic [TO_W-1:0]   idle;
  logic [DIV_W-1:0]  div_q;

  logic              tick, quiet_out, last_half;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [PROD_W-1:0] scaled;
  logic [DIV_W-1:0]  div_calc;

  assign tick      = (pre == PS_W'(TICK - 1));
  assign quiet_out = (idle == TO_W'(TIMEOUT - 1));
  assign last_half = (halves == HC_W'(HALF_CYCLES - 1));
  assign cnt_nxt   = (tick && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
  assign scaled    = (PROD_W'(cnt_nxt) * PROD_W'(CAL_DIV)) >> 8;

  always_comb begin
    if (scaled > DIV_CAP)
      div_calc = {DIV_W{1'b1}};
    else if (scaled == '0)
      div_calc = DIV_W'(1);
    else
      div_calc = scaled[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= WAIT_FIRST;
      pre    <= '0;
      cnt    <= '0;
      halves <= '0;
      idle   <= '0;
      div_q  <= '0;
    end else begin
      unique case (phase)
        WAIT_FIRST: begin
          if (zc_in) begin
            phase  <= MEASURE;
            pre    <= '0;
            cnt    <= '0;
            halves <= '0;
            idle   <= '0;
          end else if (quiet_out) begin
            phase <= FAILED;
          end else begin
            idle <= idle + 1'b1;
          end
        end
        MEASURE: begin
          pre <= tick ? '0 : pre + 1'b1;
          cnt <= cnt_nxt;
          if (zc_in) begin
            idle <= '0;
            if (last_half) begin
              phase <= CALIBRATED;
              div_q <= div_calc;
            end else begin
              halves <= halves + 1'b1;
            end
          end else if (quiet_out) begin
            phase <= FAILED;
          end else begin
            idle <= idle + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cal_done = (phase == CALIBRATED);
  assign cal_err  = (phase == FAILED);
  assign div_val  = div_q;
  assign zc_fwd   = zc_in & cal_done;
endmodule

// File: rtl/mains_cal_chk.sv
module mains_cal_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             zc_in,
  input logic             zc_fwd,
  input logic [DIV_W-1:0] div_val,
  input logic             cal_done,
  input logic             cal_err
);
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done && cal_err));

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |=> (cal_err && !cal_done));

  p_div_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (div_val != '0));

  p_div_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> $stable(div_val));

  p_fwd_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zc_fwd |-> (cal_done && zc_in));

  p_fwd_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && zc_in) |-> zc_fwd);
endmodule

bind mains_cal mains_cal_chk #(.DIV_W(DIV_W)) u_mains_cal_chk (
  .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .zc_fwd(zc_fwd),
  .div_val(div_val), .cal_done(cal_done), .cal_err(cal_err)
);

// File: tb/test_mains_cal.sv
`timescale 1ns/1ps
module test_mains_cal;
  localparam int HALF = 4;
  localparam int SLOW = 4;
  localparam int CALD = 10;
  localparam int CW   = 16;
  localparam int DW   = 4;
  localparam int TO   = 8000;
  localparam int TICK = CALD * SLOW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc = 1'b0;
  logic zc_fwd, cal_done, cal_err;
  logic [DW-1:0] div_val;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mains_cal #(.HALF_CYCLES(HALF), .SLOW_DIV(SLOW), .CAL_DIV(CALD),
              .CNT_W(CW), .DIV_W(DW), .TIMEOUT(TO)) i_mains_cal (
    .clk(clk), .rst_n(rst_n), .zc_in(zc), .zc_fwd(zc_fwd),
    .div_val(div_val), .cal_done(cal_done), .cal_err(cal_err)
  );

  // reference model: 0 waiting, 1 measuring, 2 done, 3 error
  int m_st = 0, m_since = 0, m_el = 0, m_halves = 0, m_div = 0;

  function automatic int expect_div(int span);
    int c, d;
    c = span / TICK;
    if (c > (1 << CW) - 1) c = (1 << CW) - 1;
    d = (c * CALD) >> 8;
    if (d > (1 << DW) - 1) d = (1 << DW) - 1;
    if (d == 0) d = 1;
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_since = 0; m_el = 0; m_halves = 0; m_div = 0;
    end else if (m_st == 0) begin
      if (zc) begin
        m_st = 1; m_el = 0; m_halves = 0; m_since = 0;
      end else begin
        m_since++;
        if (m_since == TO) m_st = 3;
      end
    end else if (m_st == 1) begin
      m_el++;
      if (zc) begin
        m_since = 0;
        m_halves++;
        if (m_halves == HALF) begin
          m_div = expect_div(m_el);
          m_st = 2;
        end
      end else begin
        m_since++;
        if (m_since == TO) m_st = 3;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      check("R3", "cal_done", int'(cal_done), int'(m_st == 2));
      check("R8", "cal_err", int'(cal_err), int'(m_st == 3));
      check("R4", "div_val", int'(div_val), m_div);
      check("R7", "zc_fwd", int'(zc_fwd), int'(zc && m_st == 2));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    zc = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "done in reset", int'(cal_done), 0);
    check("R1", "err in reset", int'(cal_err), 0);
    check("R1", "div in reset", int'(div_val), 0);
    check("R1", "fwd in reset", int'(zc_fwd), 0);
    rst_n = 1'b1;
  endtask

  task automatic pulse();
    @(negedge clk) zc = 1'b1;
    @(negedge clk) zc = 1'b0;
  endtask

  task automatic pulses(int n, int per);
    for (int i = 0; i < n; i++) begin
      pulse();
      if (i != n - 1) repeat (per - 2) @(negedge clk);
    end
  endtask

  task automatic calib(string req, int per, int exp_div);
    do_reset();
    repeat (5) @(negedge clk);
    pulses(HALF + 1, per);
    repeat (2) @(negedge clk);
    check("R3", "done after run", int'(cal_done), 1);
    check(req, "divider", int'(div_val), exp_div);
  endtask

  task automatic run_all();
    calib("R2", 2560, 10);
    calib("R4", 2000, 7);
    calib("R4", 1600, 6);
    repeat (100) @(negedge clk);
    pulse();
    check("R9", "div after extra crossing", int'(div_val), 6);
    calib("R5", 5000, 15);
    calib("R6", 100, 1);

    // uneven spacing: spans 1000+3000+1500+2500 = 8000 -> 200 -> 7
    do_reset();
    pulse(); repeat (998) @(negedge clk);
    pulse(); repeat (2998) @(negedge clk);
    pulse(); repeat (1498) @(negedge clk);
    pulse(); repeat (2498) @(negedge clk);
    check("R3", "not done before last pulse", int'(cal_done), 0);
    pulse();
    repeat (2) @(negedge clk);
    check("R2", "uneven spacing divider", int'(div_val), 7);

    // timeout from reset
    do_reset();
    repeat (TO - 5) @(negedge clk);
    check("R8", "no early error", int'(cal_err), 0);
    repeat (10) @(negedge clk);
    check("R8", "error from silence", int'(cal_err), 1);
    pulses(HALF + 1, 200);
    check("R8", "done stays low after error", int'(cal_done), 0);

    // timeout mid-measurement
    do_reset();
    pulses(2, 500);
    repeat (TO + 10) @(negedge clk);
    check("R8", "error mid-measure", int'(cal_err), 1);
    check("R8", "no done mid-measure", int'(cal_done), 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule